// File: doc/BRIEF.md
# GPIO Port with Grouped Interrupt Outputs

This block is a memory-mapped general-purpose I/O port of up to 32 pins on a simple 32-bit register bus. Software sets each pin's direction, output level and blink enable. Each pin is sampled through a two-flop synchroniser and then passed through a per-pin polarity inversion. The result is visible as a read-only data-in word, so active-low lines and falling events both appear as a 1.

Two interrupt paths run from the polarity-corrected data-in word. The level path uses the data-in bit directly. The edge path latches each 0-to-1 transition of data-in into a sticky cause bit, which software clears by writing 0. Each path has its own mask register. Every group of eight pins ORs its masked causes onto one interrupt request line. An output pin with blink enabled follows a free-running toggle with a programmable half-period instead of its output bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset every pin is an input (`pad_oe` all 0, direction reads all ones). The output, blink, polarity, edge-cause, edge-mask and level-mask registers read 0, and `irq` is 0.
- R2: Output (0x00), direction (0x04), blink enable (0x08) and polarity (0x0C) read back what was written. Data-in (0x10) is read-only, so writes to it have no effect.
- R3: The edge mask is at 0x18 + MASK_OFS and the level mask is at 0x1C + MASK_OFS. Any unmapped address reads 0 and accepts writes with no effect.
- R4: A direction bit of 1 turns off that pin's driver (`pad_oe`=0). A direction bit of 0 drives the pin (`pad_oe`=1) with its output-register bit when blink is off.
- R5: Data-in bit n reads pad n XOR polarity bit n. A pad change becomes visible after two rising clock edges.
- R6: An edge-cause bit is set one clock after its data-in bit goes from 0 to 1. This includes a rise caused by a polarity change. The bit stays set until cleared.
- R7: A write to edge cause (0x14) clears each bit written 0 and leaves each bit written 1 unchanged.
- R8: If an edge sets a cause bit in the same cycle that a write clears it, the bit stays set.
- R9: The per-pin interrupt source is (data-in AND level mask) OR (edge cause AND edge mask). It is not latched on the level path.
- R10: For a pin that is an output with blink enabled, `pad_out` toggles every BLINK_HALF clock cycles.
- R11: Pins 8k..8k+7 drive `irq[k]` and no other interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | NPINS | Pin levels from the pads |
| pad_out | output | NPINS | Pin drive values |
| pad_oe | output | NPINS | Pin driver enables, 1 = drive |
| irq | output | (NPINS+7)/8 | Grouped interrupt requests |

## Verification
The hardest case to reach is a new edge arriving in exactly the cycle that software clears the same cause bit. From the ports, this means placing a bus write three clock edges after a pad change, counting through both synchroniser flops and the previous-value register. The bench changes one pad at a falling edge and counts two more falling edges. It then issues the clearing write so that the write lands on the cycle where the cause latches, and reads the bit back afterwards. A random phase mixes pad, polarity, mask and clear operations and compares data-in, cause and `irq` against a bench model after each step settles.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int WORD_W  = 32;
    localparam int GROUP_W = 8;

    localparam logic [31:0] OFS_OUT   = 32'h00;
    localparam logic [31:0] OFS_DIR   = 32'h04;
    localparam logic [31:0] OFS_BLINK = 32'h08;
    localparam logic [31:0] OFS_POL   = 32'h0C;
    localparam logic [31:0] OFS_DIN   = 32'h10;
    localparam logic [31:0] OFS_CAUSE = 32'h14;
    localparam logic [31:0] OFS_EMASK = 32'h18;
    localparam logic [31:0] OFS_LMASK = 32'h1C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_OUT, SEL_DIR, SEL_BLINK, SEL_POL,
        SEL_DIN, SEL_CAUSE, SEL_EMASK, SEL_LMASK
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] lvl_mask;
        logic [WORD_W-1:0] edge_mask;
        logic [WORD_W-1:0] pol;
        logic [WORD_W-1:0] blink;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] out;
    } ctrl_regs_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a, input logic [31:0] mofs);
        reg_sel_e s;
        s = SEL_NONE;
        if      (a == OFS_OUT)          s = SEL_OUT;
        else if (a == OFS_DIR)          s = SEL_DIR;
        else if (a == OFS_BLINK)        s = SEL_BLINK;
        else if (a == OFS_POL)          s = SEL_POL;
        else if (a == OFS_DIN)          s = SEL_DIN;
        else if (a == OFS_CAUSE)        s = SEL_CAUSE;
        else if (a == OFS_EMASK + mofs) s = SEL_EMASK;
        else if (a == OFS_LMASK + mofs) s = SEL_LMASK;
        return s;
    endfunction

    function automatic logic [31:0] pin_mask(input int n);
        if (n >= 32) return '1;
        return (32'h1 << n) - 32'h1;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int AW       = 8,
    parameter int MASK_OFS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       din,
    input  logic [31:0]       cause,
    output ctrl_regs_t        regs,
    output logic              cause_wr,
    output logic [31:0]       bus_rdata
);
    localparam logic [31:0] PMASK = pin_mask(NPINS);

    reg_sel_e sel;
    assign sel      = decode_addr(32'(bus_addr), 32'(MASK_OFS));
    assign cause_wr = bus_we && (sel == SEL_CAUSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.out       <= '0;
            regs.dir       <= PMASK;
            regs.blink     <= '0;
            regs.pol       <= '0;
            regs.edge_mask <= '0;
            regs.lvl_mask  <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_OUT:   regs.out       <= bus_wdata & PMASK;
                SEL_DIR:   regs.dir       <= bus_wdata & PMASK;
                SEL_BLINK: regs.blink     <= bus_wdata & PMASK;
                SEL_POL:   regs.pol       <= bus_wdata & PMASK;
                SEL_EMASK: regs.edge_mask <= bus_wdata & PMASK;
                SEL_LMASK: regs.lvl_mask  <= bus_wdata & PMASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_OUT:   bus_rdata = regs.out;
            SEL_DIR:   bus_rdata = regs.dir;
            SEL_BLINK: bus_rdata = regs.blink;
            SEL_POL:   bus_rdata = regs.pol;
            SEL_DIN:   bus_rdata = din;
            SEL_CAUSE: bus_rdata = cause;
            SEL_EMASK: bus_rdata = regs.edge_mask;
            SEL_LMASK: bus_rdata = regs.lvl_mask;
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    din_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_DIN) |=> $stable(regs));

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    input  logic [31:0]      pol,
    input  logic             cause_wr,
    input  logic [31:0]      cause_keep,
    output logic [31:0]      din,
    output logic [31:0]      cause
);
    logic [31:0] synced;
    logic [31:0] prev_q;
    logic [31:0] rise;

    for (genvar i = 0; i < WORD_W; i++) begin : g_pin
        if (i < NPINS) begin : g_live
            logic s1, s2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= pad_in[i];
                    s2 <= s1;
                end
            end
            assign synced[i] = s2;
        end else begin : g_tie
            assign synced[i] = 1'b0;
        end
    end

    assign din  = synced ^ pol;
    assign rise = din & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cause  <= '0;
        end else begin
            prev_q <= din;
            cause  <= (cause_wr ? (cause & cause_keep) : cause) | rise;
        end
    end

    // R6
    edge_src_chk: assert property (@(posedge clk) disable iff (rst)
        (cause & ~$past(cause) & ~$past(rise)) == '0);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((cause & $past(rise)) == $past(rise)));

endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
    parameter int BLINK_HALF = 12_500_000
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int CW = $clog2(BLINK_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R10
    blink_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_port_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     src,
    output logic [NIRQ-1:0] irq
);
    for (genvar g = 0; g < NIRQ; g++) begin : g_grp
        assign irq[g] = |src[g*GROUP_W +: GROUP_W];
    end

    // R11
    irq_any_chk: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) == (src[NIRQ*GROUP_W-1:0] != '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int AW         = 8,
    parameter int MASK_OFS   = 0,
    parameter int BLINK_HALF = 12_500_000,
    localparam int NIRQ      = (NPINS + GROUP_W - 1) / GROUP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NIRQ-1:0]  irq
);
    ctrl_regs_t  regs;
    logic        cause_wr;
    logic [31:0] din, cause, irq_src, drive_w;
    logic        phase;

    gpio_regs #(.NPINS(NPINS), .AW(AW), .MASK_OFS(MASK_OFS)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .din(din), .cause(cause), .regs(regs),
        .cause_wr(cause_wr), .bus_rdata(bus_rdata)
    );

    gpio_insync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pol(regs.pol),
        .cause_wr(cause_wr), .cause_keep(bus_wdata), .din(din), .cause(cause)
    );

    gpio_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst(rst), .phase(phase)
    );

    assign irq_src = (din & regs.lvl_mask) | (cause & regs.edge_mask);

    gpio_irq_merge #(.NIRQ(NIRQ)) u_merge (
        .clk(clk), .rst(rst), .src(irq_src), .irq(irq)
    );

    assign drive_w = (regs.blink & {32{phase}}) | (regs.out & ~regs.blink);
    assign pad_out = drive_w[NPINS-1:0];
    assign pad_oe  = ~regs.dir[NPINS-1:0];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && irq == '0));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DIR[AW-1:0]) |=> (pad_oe == ~NPINS'($past(bus_wdata))));

endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    localparam int NP   = 32;
    localparam int AW   = 8;
    localparam int MOFS = 32;
    localparam int HALF = 8;
    localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLK = 8'h08, A_POL = 8'h0C,
                           A_DIN = 8'h10, A_CAU = 8'h14, A_EM = 8'h38, A_LM = 8'h3C;

    logic clk = 0, rst = 1;
    logic [AW-1:0] bus_addr = '0;
    logic bus_we = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic [3:0] irq;

    int tests = 0, fails = 0;
    logic [31:0] m_out, m_dir, m_blk, m_pol, m_em, m_lm, m_cau, m_pad;

    always #4 clk = ~clk;

    gpio_irq_port #(.NPINS(NP), .AW(AW), .MASK_OFS(MOFS), .BLINK_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_irq();
        logic [31:0] s;
        logic [3:0] r;
        s = ((m_pad ^ m_pol) & m_lm) | (m_cau & m_em);
        for (int g = 0; g < 4; g++) r[g] = |s[g*8 +: 8];
        return r;
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic note_din(input logic [31:0] npad, input logic [31:0] npol);
        m_cau = m_cau | ((npad ^ npol) & ~(m_pad ^ m_pol));
        m_pad = npad; m_pol = npol;
    endtask

    task automatic set_pol(input logic [31:0] p);
        note_din(m_pad, p);
        wr(A_POL, p);
        settle();
    endtask

    task automatic set_pad(input logic [31:0] p);
        @(negedge clk);
        note_din(p, m_pol);
        pad_in = p;
        settle();
    endtask

    task automatic check_state(input string tag);
        logic [31:0] d;
        rd(A_DIN, d); chk({tag, " R5 din"}, d, m_pad ^ m_pol);
        rd(A_CAU, d); chk({tag, " R6 cause"}, d, m_cau);
        chk({tag, " R9 irq"}, {28'h0, irq}, {28'h0, exp_irq()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, v;
        int n, op;
        void'($urandom(32'd1234));
        m_out = 0; m_dir = '1; m_blk = 0; m_pol = 0; m_em = 0; m_lm = 0; m_cau = 0; m_pad = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", {0'b0, pad_oe}, 32'h0);
        chk("R1 irq", {28'h0, irq}, 32'h0);
        rd(A_DIR, d); chk("R1 dir", d, 32'hFFFF_FFFF);
        rd(A_OUT, d); chk("R1 out", d, 0);
        rd(A_BLK, d); chk("R1 blink", d, 0);
        rd(A_POL, d); chk("R1 pol", d, 0);
        rd(A_CAU, d); chk("R1 cause", d, 0);
        rd(A_EM, d);  chk("R1 emask", d, 0);
        rd(A_LM, d);  chk("R1 lmask", d, 0);

        // R2 readback and read-only data-in
        m_out = $urandom; wr(A_OUT, m_out); rd(A_OUT, d); chk("R2 out", d, m_out);
        set_pol(32'h0F0F_00FF); rd(A_POL, d); chk("R2 pol", d, m_pol);
        wr(A_DIN, 32'hDEAD_BEEF); rd(A_DIN, d); chk("R2 din ro", d, m_pad ^ m_pol);
        check_state("R2");
        wr(A_CAU, 0); m_cau = 0;
        rd(A_CAU, d); chk("R7 clear all", d, 0);

        // R3 relocated masks, unmapped hole
        m_em = 32'h1234_5678; wr(A_EM, m_em);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R3 hole read", d, 0);
        rd(A_EM, d); chk("R3 emask", d, m_em);
        m_lm = 32'h0000_0000; wr(A_LM, m_lm);

        // R4 direction / drive
        m_dir = 32'hA5A5_0F0F; wr(A_DIR, m_dir);
        rd(A_DIR, d); chk("R2 dir", d, m_dir);
        @(negedge clk);
        chk("R4 oe", pad_oe, ~m_dir);
        chk("R4 drive", pad_out & pad_oe, m_out & ~m_dir);

        // random mix
        for (int it = 0; it < 60; it++) begin
            op = $urandom_range(0, 4);
            case (op)
                0: set_pad($urandom);
                1: set_pol($urandom);
                2: begin m_em = $urandom; wr(A_EM, m_em); end
                3: begin m_lm = $urandom & $urandom; wr(A_LM, m_lm); end
                default: begin v = $urandom; wr(A_CAU, v); m_cau = m_cau & v; end
            endcase
            @(negedge clk);
            check_state("RND");
        end

        // R7 partial clear
        m_pol = 0; wr(A_POL, 0); set_pad(0); set_pad(32'h0000_0300);
        wr(A_CAU, ~32'h0000_0100); m_cau = m_cau & ~32'h0000_0100;
        rd(A_CAU, d); chk("R7 partial clear", d & 32'h300, 32'h200);
        wr(A_CAU, 0); m_cau = 0; set_pad(0); wr(A_CAU, 0); m_cau = 0;

        // R5/R6 timing on pin 5
        @(negedge clk); pad_in = 32'h20; m_pad = 32'h20;
        @(negedge clk); rd(A_DIN, d); chk("R5 one edge", d & 32'h20, 0);
        @(negedge clk); rd(A_DIN, d); chk("R5 two edges", d & 32'h20, 32'h20);
        rd(A_CAU, d); chk("R6 not yet", d & 32'h20, 0);
        @(negedge clk); rd(A_CAU, d); chk("R6 latched", d & 32'h20, 32'h20);
        m_cau = 32'h20;

        // R8 set beats clear, pin 9
        @(negedge clk); pad_in = 32'h220; m_pad = 32'h220;
        @(negedge clk); @(negedge clk);
        bus_addr = A_CAU; bus_we = 1; bus_wdata = ~32'h200;
        @(negedge clk); bus_we = 0;
        rd(A_CAU, d); chk("R8 set wins", d & 32'h220, 32'h220);
        m_cau = 32'h220;
        wr(A_CAU, 0); m_cau = 0;

        // R11 grouping
        set_pad(0); wr(A_CAU, 0); m_cau = 0;
        m_em = 0; wr(A_EM, 0);
        for (int k = 0; k < 32; k += 7) begin
            m_lm = 32'h1 << k; wr(A_LM, m_lm);
            set_pol(32'h1 << k);
            chk($sformatf("R11 pin %0d", k), {28'h0, irq}, 32'h1 << (k / 8));
        end
        m_lm = 0; wr(A_LM, 0);

        // R10 blink on pin 0, pin 1 static high
        m_dir = 32'hFFFF_FFFC; wr(A_DIR, m_dir);
        wr(A_OUT, 32'h2); wr(A_BLK, 32'h1);
        for (int rep = 0; rep < 2; rep++) begin
            v = {31'h0, pad_out[0]};
            n = 0;
            while (pad_out[0] == v[0] && n < 100) begin @(negedge clk); n++; end
            v = {31'h0, pad_out[0]};
            n = 0;
            while (pad_out[0] == v[0] && n < 100) begin @(negedge clk); n++; end
            chk("R10 half period", n, HALF);
            chk("R10 static pin", {31'h0, pad_out[1]}, 1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule